// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Flags

This block is a first-in first-out buffer for 9-bit words whose write side and read side each run on their own clock. The two clocks may be one and the same or fully unrelated. Each side keeps a binary pointer and publishes a Gray-coded copy of it. The other side samples that copy through a chain of synchronizing flops before it compares the pointers, so a pointer crossing a clock boundary never changes more than one bit at a time.

The write side owns the full flag and the almost-full flag. The read side owns the empty flag and the almost-empty flag. The almost flags compare the fill level against two offset registers, and both offsets come out of reset at 7. A second write-side control pin plays one of two roles, chosen by its level while reset is high. In normal mode it is an extra write enable. In configuration mode it is a strobe for the offset registers: with the strobe low, writes load the offset registers and reads return them, one 8-bit slice at a time. The read data has an active-low output enable; when the enable is inactive, the read-data pins are high impedance.

Top module: `dcfifo_pflag`

## Requirements
- R1: While `rst` is high for at least 6 cycles of each clock, the block takes this state: `empty`=1, `almost_empty`=1, `full`=0, `almost_full`=0, both offsets equal 7, and `rd_data` reads 0 while `rd_oe_n`=0.
- R2: A word is stored on a `wr_clk` rising edge only when `wr_en_n`=0 and `wr_en2_ld`=1. The other three combinations of these two pins store nothing.
- R3: A read happens on a `rd_clk` rising edge when `rd_en1_n`=0, `rd_en2_n`=0 and `empty`=0, and the word appears on `rd_data` after that edge. Words leave in the order they were stored.
- R4: When `rd_oe_n`=1, every bit of `rd_data` is high impedance. When `rd_oe_n` returns to 0, the held word reappears unchanged.
- R5: `full` rises once 2^ADDR_W words are stored. A write attempted while `full`=1 is dropped, and after one read `full` falls again.
- R6: A read attempted while `empty`=1 is dropped: `rd_data` keeps its value and the read pointer does not move.
- R7: `almost_empty` is 1 exactly when the stored count is at most the empty offset. It is updated on `rd_clk` edges.
- R8: `almost_full` is 1 exactly when the number of free locations is at most the full offset. It is updated on `wr_clk` edges, so it falls as soon as the free count exceeds the offset.
- R9: If `wr_en2_ld`=0 while `rst` is high, the block is in configuration mode. In this mode each `wr_clk` edge with `wr_en_n`=0 and `wr_en2_ld`=0 loads one offset slice from `wr_data`, and no FIFO word is stored. The slices are written in a fixed wrapping order: empty offset bits [7:0], empty offset bits [9:8] (taken from `wr_data[1:0]`), full offset bits [7:0], full offset bits [9:8]. In this mode, an edge with `wr_en_n`=0 and `wr_en2_ld`=1 is an ordinary FIFO write.
- R10: In configuration mode, each `rd_clk` edge with both read enables at 0 and `wr_en2_ld`=0 puts the next offset slice on `rd_data`, zero-extended to 9 bits. The read order is the same as the load order and starts at the empty-offset low slice after reset. These reads leave the FIFO untouched.
- R11: Each Gray-coded pointer changes by at most one bit per edge of its own clock.
- R12: `full` never holds without `almost_full`, and `empty` never holds without `almost_empty`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks |
| wr_en_n | input | 1 | Active-low write enable |
| wr_en2_ld | input | 1 | Second write enable (normal mode) or offset load strobe, active low (configuration mode) |
| wr_data | input | DATA_W | Write word or offset slice |
| rd_en1_n | input | 1 | Active-low read enable, first |
| rd_en2_n | input | 1 | Active-low read enable, second |
| rd_oe_n | input | 1 | Active-low output enable for `rd_data` |
| rd_data | output | DATA_W | Read word or offset slice; high impedance when disabled |
| empty | output | 1 | No word stored (read domain) |
| almost_empty | output | 1 | Stored count at or below the empty offset (read domain) |
| full | output | 1 | All locations used (write domain) |
| almost_full | output | 1 | Free count at or below the full offset (write domain) |

## Verification
A write pointer that advances when it should not would make extra or repeated words appear in the read stream. It would also make the stored count drift, so `empty` would no longer rise after exactly as many reads as there were accepted writes; a stream of 2^ADDR_W words shows the drift by the final drain. A read pointer that moves while the buffer is empty would skip the next written word, and the first read after that write exposes it. An offset register loaded in the wrong slice shows up in the readback on the next four reads. Once a few cycles have passed for the pointer synchronizers, a flag threshold that is off by one word shows up as a wrong `almost_empty` or `almost_full` level at the single-word boundary.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  // Offset slices in load/readback order; the order is behaviour.
  typedef enum logic [1:0] {
    SLOT_EMPTY_LO = 2'd0,
    SLOT_EMPTY_HI = 2'd1,
    SLOT_FULL_LO  = 2'd2,
    SLOT_FULL_HI  = 2'd3
  } ofs_slot_e;

  function automatic ofs_slot_e slot_next(input ofs_slot_e s);
    return ofs_slot_e'(s + 2'd1);
  endfunction

endpackage

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int DW = 9,
  parameter int AW = 10
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dcf_ptr_sync.sv
module dcf_ptr_sync #(
  parameter int W      = 11,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side
  import dcf_pkg::*;
#(
  parameter int AW       = 10,
  parameter int OFS_INIT = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en1_n,
  input  logic          en2_ld,
  input  logic [7:0]    ofs_din,
  input  logic [AW:0]   rgray_s,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [AW:0]   wgray,
  output logic          full,
  output logic          afull,
  output logic          ld_mode,
  output logic [AW-1:0] empty_ofs,
  output logic [AW-1:0] full_ofs
);
  // Offset is split into an 8-bit low slice and an (AW-8)-bit high slice; AW must exceed 8.
  localparam int PW = AW + 1;
  localparam int LW = 8;
  localparam int HW = AW - LW;
  localparam logic [PW-1:0] FULL_CNT = {1'b1, {AW{1'b0}}};

  logic [PW-1:0] wbin, wbin_nxt, rbin_s, used_nxt, free_nxt;
  logic          fifo_req, do_wr, ofs_wr;
  ofs_slot_e     wslot;

  // Gray to binary: each bit is the XOR of itself and all higher bits.
  always_comb begin
    for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s >> i);
  end

  assign fifo_req = !en1_n && en2_ld;
  assign do_wr    = fifo_req && !full;
  assign ofs_wr   = ld_mode && !en1_n && !en2_ld;
  assign wbin_nxt = wbin + PW'(do_wr);
  assign used_nxt = wbin_nxt - rbin_s;
  assign free_nxt = FULL_CNT - used_nxt;

  assign mem_we    = do_wr;
  assign mem_waddr = wbin[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin      <= '0;
      wgray     <= '0;
      full      <= 1'b0;
      afull     <= 1'b0;
      ld_mode   <= !en2_ld;
      wslot     <= SLOT_EMPTY_LO;
      empty_ofs <= AW'(OFS_INIT);
      full_ofs  <= AW'(OFS_INIT);
    end else begin
      wbin  <= wbin_nxt;
      wgray <= wbin_nxt ^ (wbin_nxt >> 1);
      full  <= (used_nxt == FULL_CNT);
      afull <= (free_nxt <= {1'b0, full_ofs});
      if (ofs_wr) begin
        case (wslot)
          SLOT_EMPTY_LO: empty_ofs[LW-1:0] <= ofs_din;
          SLOT_EMPTY_HI: empty_ofs[AW-1:LW] <= ofs_din[HW-1:0];
          SLOT_FULL_LO:  full_ofs[LW-1:0]  <= ofs_din;
          default:       full_ofs[AW-1:LW] <= ofs_din[HW-1:0];
        endcase
        wslot <= slot_next(wslot);
      end
    end
  end
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
  import dcf_pkg::*;
#(
  parameter int DW = 9,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en1_n,
  input  logic          en2_n,
  input  logic          ld_pin,
  input  logic [AW:0]   wgray_s,
  input  logic [AW-1:0] empty_ofs,
  input  logic [AW-1:0] full_ofs,
  output logic          mem_re,
  output logic [AW-1:0] mem_raddr,
  output logic [AW:0]   rgray,
  output logic          empty,
  output logic          aempty,
  output logic          ld_mode,
  output logic          use_ram,
  output logic [DW-1:0] ofs_q
);
  localparam int PW = AW + 1;
  localparam int LW = 8;

  logic [PW-1:0] rbin, rbin_nxt, wbin_s, used_nxt;
  logic          rd_req, ofs_rd, do_rd;
  ofs_slot_e     rslot;
  logic [DW-1:0] slot_val;

  always_comb begin
    for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
  end

  assign rd_req   = !en1_n && !en2_n;
  assign ofs_rd   = rd_req && ld_mode && !ld_pin;
  assign do_rd    = rd_req && !ofs_rd && !empty;
  assign rbin_nxt = rbin + PW'(do_rd);
  assign used_nxt = wbin_s - rbin_nxt;

  assign mem_re    = do_rd;
  assign mem_raddr = rbin[AW-1:0];

  always_comb begin
    case (rslot)
      SLOT_EMPTY_LO: slot_val = DW'(empty_ofs[LW-1:0]);
      SLOT_EMPTY_HI: slot_val = DW'(empty_ofs[AW-1:LW]);
      SLOT_FULL_LO:  slot_val = DW'(full_ofs[LW-1:0]);
      default:       slot_val = DW'(full_ofs[AW-1:LW]);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin    <= '0;
      rgray   <= '0;
      empty   <= 1'b1;
      aempty  <= 1'b1;
      ld_mode <= !ld_pin;
      rslot   <= SLOT_EMPTY_LO;
      use_ram <= 1'b0;
      ofs_q   <= '0;
    end else begin
      rbin   <= rbin_nxt;
      rgray  <= rbin_nxt ^ (rbin_nxt >> 1);
      empty  <= (used_nxt == '0);
      aempty <= (used_nxt <= {1'b0, empty_ofs});
      if (do_rd) use_ram <= 1'b1;
      if (ofs_rd) begin
        use_ram <= 1'b0;
        ofs_q   <= slot_val;
        rslot   <= slot_next(rslot);
      end
    end
  end
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag #(
  parameter int DATA_W      = 9,
  parameter int ADDR_W      = 10,
  parameter int OFS_DEFAULT = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst,
  input  logic              wr_en_n,
  input  logic              wr_en2_ld,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en1_n,
  input  logic              rd_en2_n,
  input  logic              rd_oe_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              almost_empty,
  output logic              full,
  output logic              almost_full
);
  localparam int PW = ADDR_W + 1;

  logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
  logic              mem_we, mem_re, wr_ld_mode, rd_ld_mode, use_ram;
  logic [ADDR_W-1:0] waddr, raddr, empty_ofs, full_ofs;
  logic [DATA_W-1:0] ram_q, ofs_q, rd_q;

  dcf_wr_side #(.AW(ADDR_W), .OFS_INIT(OFS_DEFAULT)) u_wr (
    .clk(wr_clk), .rst(rst), .en1_n(wr_en_n), .en2_ld(wr_en2_ld),
    .ofs_din(wr_data[7:0]), .rgray_s(rgray_s), .mem_we(mem_we),
    .mem_waddr(waddr), .wgray(wgray), .full(full), .afull(almost_full),
    .ld_mode(wr_ld_mode), .empty_ofs(empty_ofs), .full_ofs(full_ofs)
  );

  dcf_rd_side #(.DW(DATA_W), .AW(ADDR_W)) u_rd (
    .clk(rd_clk), .rst(rst), .en1_n(rd_en1_n), .en2_n(rd_en2_n),
    .ld_pin(wr_en2_ld), .wgray_s(wgray_s), .empty_ofs(empty_ofs),
    .full_ofs(full_ofs), .mem_re(mem_re), .mem_raddr(raddr), .rgray(rgray),
    .empty(empty), .aempty(almost_empty), .ld_mode(rd_ld_mode),
    .use_ram(use_ram), .ofs_q(ofs_q)
  );

  dcf_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst(rst), .d(wgray), .q(wgray_s)
  );

  dcf_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst(rst), .d(rgray), .q(rgray_s)
  );

  dcf_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
    .wclk(wr_clk), .we(mem_we), .waddr(waddr), .wdata(wr_data),
    .rclk(rd_clk), .re(mem_re), .raddr(raddr), .rdata(ram_q)
  );

  assign rd_q    = use_ram ? ram_q : ofs_q;
  assign rd_data = rd_oe_n ? {DATA_W{1'bz}} : rd_q;
endmodule

// File: rtl/dcf_chk.sv
module dcf_chk #(
  parameter int PW = 11
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst,
  input logic          wr_en_n,
  input logic          wr_en2_ld,
  input logic          rd_en1_n,
  input logic          rd_en2_n,
  input logic          empty,
  input logic          almost_empty,
  input logic          full,
  input logic          almost_full,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rgray,
  input logic          wr_ld_mode,
  input logic          rd_ld_mode
);
  // R2
  wr_qual_chk: assert property (@(posedge wr_clk) disable iff (rst)
    (wr_en_n || !wr_en2_ld) |=> $stable(wgray));

  // R5
  no_overflow_chk: assert property (@(posedge wr_clk) disable iff (rst)
    (full && !wr_en_n && wr_en2_ld) |=> $stable(wgray));

  // R6
  no_underflow_chk: assert property (@(posedge rd_clk) disable iff (rst)
    (empty && !rd_en1_n && !rd_en2_n) |=> $stable(rgray));

  // R9
  ld_no_push_chk: assert property (@(posedge wr_clk) disable iff (rst)
    (wr_ld_mode && !wr_en_n && !wr_en2_ld) |=> $stable(wgray));

  // R10
  ld_no_pop_chk: assert property (@(posedge rd_clk) disable iff (rst)
    (rd_ld_mode && !wr_en2_ld && !rd_en1_n && !rd_en2_n) |=> $stable(rgray));

  // R11
  wgray_step_chk: assert property (@(posedge wr_clk) disable iff (rst)
    $countones(wgray ^ $past(wgray)) <= 1);

  // R11
  rgray_step_chk: assert property (@(posedge rd_clk) disable iff (rst)
    $countones(rgray ^ $past(rgray)) <= 1);

  // R12
  full_af_chk: assert property (@(posedge wr_clk) disable iff (rst)
    full |-> almost_full);

  // R12
  empty_ae_chk: assert property (@(posedge rd_clk) disable iff (rst)
    empty |-> almost_empty);
endmodule

bind dcfifo_pflag dcf_chk #(.PW(ADDR_W + 1)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .wr_en_n(wr_en_n),
  .wr_en2_ld(wr_en2_ld), .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n),
  .empty(empty), .almost_empty(almost_empty), .full(full),
  .almost_full(almost_full), .wgray(wgray), .rgray(rgray),
  .wr_ld_mode(wr_ld_mode), .rd_ld_mode(rd_ld_mode)
);

// File: tb/test_dcfifo_pflag.sv
module test_dcfifo_pflag;
  localparam int DW    = 9;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;

  logic wclk = 1'b0, rclk = 1'b0, rst = 1'b1;
  logic wr_en_n = 1'b1, wr_en2_ld = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic rd_en1_n = 1'b1, rd_en2_n = 1'b1, rd_oe_n = 1'b0;
  logic [DW-1:0] rd_data;
  logic empty, almost_empty, full, almost_full;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #5 wclk = ~wclk;
  always #7 rclk = ~rclk;

  dcfifo_pflag #(.DATA_W(DW), .ADDR_W(AW)) i_dcfifo_pflag (
    .wr_clk(wclk), .rd_clk(rclk), .rst(rst), .wr_en_n(wr_en_n),
    .wr_en2_ld(wr_en2_ld), .wr_data(wr_data), .rd_en1_n(rd_en1_n),
    .rd_en2_n(rd_en2_n), .rd_oe_n(rd_oe_n), .rd_data(rd_data),
    .empty(empty), .almost_empty(almost_empty), .full(full),
    .almost_full(almost_full)
  );

  // {wr_en_n, wr_en2_ld, data}; stored only when 0,1 (R2)
  localparam logic [10:0] VEC [8] = '{
    {2'b01, 9'h011}, {2'b11, 9'h022}, {2'b00, 9'h033}, {2'b01, 9'h144},
    {2'b10, 9'h055}, {2'b01, 9'h066}, {2'b01, 9'h1FF}, {2'b11, 9'h000}
  };

  function automatic logic [DW-1:0] pat(input int k);
    return DW'((k * 37 + 5) % 512);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  task automatic settle();
    repeat (8) @(negedge wclk);
    repeat (8) @(negedge rclk);
  endtask

  task automatic do_reset(input bit cfg);
    @(negedge wclk);
    rst = 1'b1; wr_en_n = 1'b1; wr_en2_ld = !cfg;
    repeat (6) @(negedge wclk);
    repeat (6) @(negedge rclk);
    @(negedge wclk);
    rst = 1'b0;
    settle();
  endtask

  task automatic push_stream(input int n, input int base);
    @(negedge wclk);
    wr_en2_ld = 1'b1;
    for (int i = 0; i < n; i++) begin
      wr_en_n = 1'b0; wr_data = pat(base + i);
      @(negedge wclk);
    end
    wr_en_n = 1'b1;
  endtask

  task automatic push_word(input logic [DW-1:0] d);
    @(negedge wclk);
    wr_en2_ld = 1'b1; wr_en_n = 1'b0; wr_data = d;
    @(negedge wclk);
    wr_en_n = 1'b1;
  endtask

  task automatic rd_pulse(output logic [DW-1:0] v);
    @(negedge rclk);
    rd_en1_n = 1'b0; rd_en2_n = 1'b0;
    @(negedge rclk);
    rd_en1_n = 1'b1; rd_en2_n = 1'b1;
    v = rd_data;
  endtask

  task automatic pop(output logic [DW-1:0] v);
    @(negedge rclk);
    while (empty) @(negedge rclk);
    rd_en1_n = 1'b0; rd_en2_n = 1'b0;
    @(negedge rclk);
    rd_en1_n = 1'b1; rd_en2_n = 1'b1;
    v = rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge wclk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    logic [DW-1:0] v, held;
    int bad, nexp;

    // R1 reset state, normal mode
    do_reset(1'b0);
    chk("R1 empty", empty, 1);
    chk("R1 almost_empty", almost_empty, 1);
    chk("R1 full", full, 0);
    chk("R1 almost_full", almost_full, 0);
    chk("R1 rd_data", rd_data, 0);

    // R4 output enable
    rd_oe_n = 1'b1; #1;
    chk("R4 high-z", (rd_data === {DW{1'bz}}), 1);
    rd_oe_n = 1'b0; #1;
    chk("R4 restore", rd_data, 0);

    // R2 / R3 vector table
    nexp = 0;
    @(negedge wclk);
    foreach (VEC[i]) begin
      wr_en_n = VEC[i][10]; wr_en2_ld = VEC[i][9]; wr_data = VEC[i][8:0];
      @(negedge wclk);
    end
    wr_en_n = 1'b1; wr_en2_ld = 1'b1;
    settle();
    foreach (VEC[i]) begin
      if (VEC[i][10:9] == 2'b01) begin
        pop(v);
        chk("R3 order", v, VEC[i][8:0]);
        nexp++;
      end
    end
    settle();
    chk("R2 only qualified writes stored", empty, 1);

    // R6 reads while empty are dropped
    held = rd_data;
    for (int k = 0; k < 3; k++) begin
      rd_pulse(v);
      chk("R6 data held", v, held);
    end
    push_word(9'h1A5);
    pop(v);
    chk("R6 pointer unmoved", v, 9'h1A5);

    // R7 almost-empty threshold with default offset 7
    settle();
    push_stream(7, 20);
    settle();
    chk("R7 seven stored", almost_empty, 1);
    chk("R7 not empty", empty, 0);
    push_stream(1, 27);
    settle();
    chk("R7 eight stored", almost_empty, 0);
    pop(v);
    chk("R7 first word", v, pat(20));
    settle();
    chk("R7 back to seven", almost_empty, 1);
    bad = 0;
    for (int k = 1; k < 8; k++) begin
      pop(v);
      if (v !== pat(20 + k)) bad++;
    end
    chk("R3 drain order", bad, 0);

    // R8 / R5 fill to the top
    settle();
    push_stream(DEPTH - 8, 100);
    settle();
    chk("R8 eight free", almost_full, 0);
    push_stream(1, 100 + DEPTH - 8);
    settle();
    chk("R8 seven free", almost_full, 1);
    push_stream(7, 100 + DEPTH - 7);
    settle();
    chk("R5 full", full, 1);
    push_word(9'h0AA);
    settle();
    chk("R5 still full", full, 1);
    pop(v);
    chk("R5 head word", v, pat(100));
    settle();
    chk("R5 full falls", full, 0);
    chk("R8 one free", almost_full, 1);
    bad = 0;
    for (int k = 1; k < DEPTH; k++) begin
      pop(v);
      if (v !== pat(100 + k)) bad++;
    end
    chk("R5 stream intact", bad, 0);
    settle();
    chk("R5 dropped word absent", empty, 1);
    chk("R8 all free", almost_full, 0);

    // R9 / R10 configuration mode
    do_reset(1'b1);
    wr_en2_ld = 1'b0;
    rd_pulse(v); chk("R10 empty lo default", v, 7);
    rd_pulse(v); chk("R10 empty hi default", v, 0);
    rd_pulse(v); chk("R10 full lo default", v, 7);
    rd_pulse(v); chk("R10 full hi default", v, 0);
    @(negedge wclk);
    wr_en_n = 1'b0; wr_data = 9'h003; @(negedge wclk);
    wr_data = 9'h000; @(negedge wclk);
    wr_data = 9'h005; @(negedge wclk);
    wr_data = 9'h001; @(negedge wclk);
    wr_en_n = 1'b1;
    settle();
    chk("R9 no word stored", empty, 1);
    rd_pulse(v); chk("R9 empty lo", v, 3);
    rd_pulse(v); chk("R9 empty hi", v, 0);
    rd_pulse(v); chk("R9 full lo", v, 5);
    rd_pulse(v); chk("R9 full hi", v, 1);
    rd_pulse(v); chk("R10 wrap", v, 3);
    push_stream(3, 300);
    settle();
    chk("R7 programmed three", almost_empty, 1);
    push_stream(1, 303);
    settle();
    chk("R7 programmed four", almost_empty, 0);
    // full offset 261: 762 stored leaves 262 free
    push_stream(DEPTH - 262 - 4, 304);
    settle();
    chk("R8 programmed 262 free", almost_full, 0);
    push_stream(1, 2000);
    settle();
    chk("R8 programmed 261 free", almost_full, 1);
    pop(v);
    chk("R9 fifo write in load mode", v, pat(300));

    done = 1'b1;
    summary();
  end
endmodule